// File: doc/BRIEF.md
# Sleep State Decoder with Guarding

This block turns the two active-low sleep request lines of a system power manager into a registered power state. The three states are active, suspend-to-RAM and soft-off. It then drives the enables for the two auxiliary rails from that state. Each request line first passes through a synchronizer. After that, a filter accepts a new level only when the level has held for a set number of timebase ticks, so a short pulse cannot put the system to sleep by mistake.

The state logic applies three guards. A request to go from active to suspend starts a delay counted in ticks, and returning to the active code before the delay ends cancels the request. A request for soft-off takes effect as soon as it is filtered. A move from soft-off straight into suspend is refused. The combination with only the suspend line high is not a legal request, so the block keeps its present state. Reset comes from power-on reset. It places the block in soft-off, because undriven request lines read low.

Top module: `sleep_state_ctrl`

## Requirements
- R1: The state code is 2'b00 for active, 2'b01 for suspend and 2'b10 for soft-off. While reset is low and after reset is released, the state is soft-off.
- R2: A filtered request code {s5_n, s3_n} of 2'b11 moves any state to active on the clock after the code is accepted.
- R3: In active, a filtered code of 2'b10 moves the state to suspend on the DELAY_TICKS-th tick after the code is accepted, and not earlier.
- R4: If the code returns to 2'b11 before that delay ends, the state stays active, and a later 2'b10 request starts a full new delay.
- R5: A filtered code of 2'b00 moves active or suspend to soft-off on the clock after the code is accepted.
- R6: In soft-off, a code of 2'b10 leaves the state in soft-off.
- R7: A code of 2'b01 leaves any state unchanged.
- R8: A new level on a request line is accepted only after FILTER_TICKS consecutive ticks at that level. A pulse lasting fewer ticks has no effect on the state.
- R9: rail_en[0] is the 3.3 V auxiliary enable and is always 1. rail_en[1] is the 5 V dual enable: it is 1 in active and in suspend, and in soft-off it equals the KEEP_5V_OFF parameter (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset from power-on reset |
| tick | input | 1 | One-clock timebase strobe (nominally 1 µs) |
| slp_s3_n | input | 1 | Active-low suspend request line |
| slp_s5_n | input | 1 | Active-low soft-off request line |
| ps_code | output | 2 | Registered power state code |
| rail_en | output | 2 | Rail enables: bit 1 is 5 V dual, bit 0 is 3.3 V auxiliary |

## Verification
The suspend delay timer and the input filter can both act on the same tick. For example, a 2'b11 or 2'b00 code can finish filtering while the delay counter is still running. The bench provokes this with the cancel scenario: it returns the lines to 2'b11 part way through the delay, then checks that the state never reaches suspend and that the next request needs the whole delay again. A sweep over every start state and every request code then compares the final state and rail enables with a table computed in the bench. The sweep uses two instances, one for each setting of the soft-off 5 V option.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'b00,
    PS_SUSPEND = 2'b01,
    PS_SOFTOFF = 2'b10
  } pstate_e;

  // Request codes seen as {s5_n, s3_n}
  localparam logic [1:0] REQ_RUN     = 2'b11;
  localparam logic [1:0] REQ_SUSPEND = 2'b10;
  localparam logic [1:0] REQ_BAD     = 2'b01;
  localparam logic [1:0] REQ_OFF     = 2'b00;

  // Next-state rule; expire marks the end of the suspend delay
  function automatic pstate_e step_state(pstate_e cur, logic [1:0] req, logic expire);
    pstate_e nxt;
    nxt = cur;
    case (req)
      REQ_RUN:     nxt = PS_ACTIVE;
      REQ_OFF:     nxt = PS_SOFTOFF;
      REQ_SUSPEND: if (cur == PS_ACTIVE && expire) nxt = PS_SUSPEND;
      default:     nxt = cur;
    endcase
    return nxt;
  endfunction

  // Rail enables: bit1 = 5V dual, bit0 = 3.3V aux
  function automatic logic [1:0] rails_for(pstate_e st, logic keep5);
    return {(st != PS_SOFTOFF) | keep5, 1'b1};
  endfunction

endpackage

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic filt
);
  localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          differs;
  logic          accept;

  assign differs = sync_q[1] != filt;
  assign accept  = differs && tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      cnt_q  <= '0;
      filt   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (!differs) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (accept) begin
          filt  <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8
  filt_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(filt));
  // R8
  filt_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/s3_delay_timer.sv
module s3_delay_timer #(
  parameter int DELAY = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic expire
);
  localparam int TW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [TW-1:0] LAST = TW'(DELAY - 1);

  logic [TW-1:0] tmr_q;

  assign expire = run && tick && (tmr_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (!run || expire) begin
      tmr_q <= '0;
    end else if (tick) begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  // R4
  tmr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> tmr_q == '0);
  // R3
  tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= LAST);

endmodule

// File: rtl/power_state_fsm.sv
module power_state_fsm
  import slp_pkg::*;
#(
  parameter bit KEEP_5V_OFF = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       expire,
  output pstate_e    state,
  output logic       delay_run,
  output logic [1:0] rails
);
  logic blocked_move;
  logic illegal_code;

  assign delay_run    = (state == PS_ACTIVE) && (req == REQ_SUSPEND);
  assign blocked_move = (state == PS_SOFTOFF) && (req == REQ_SUSPEND);
  assign illegal_code = (req == REQ_BAD);
  assign rails        = rails_for(state, KEEP_5V_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_SOFTOFF;
    else        state <= step_state(state, req, expire);
  end

  // R6
  no_off_to_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_move |=> state == PS_SOFTOFF);
  // R7
  bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_code |=> state == $past(state));
  // R5
  off_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req == REQ_OFF |=> state == PS_SOFTOFF);
  // R3
  suspend_needs_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ACTIVE && !expire) |=> state != PS_SUSPEND);
  // R9
  aux_always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rails[0]);
  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11);

endmodule

// File: rtl/sleep_state_ctrl.sv
module sleep_state_ctrl
  import slp_pkg::*;
#(
  parameter int FILTER_TICKS = 4,
  parameter int DELAY_TICKS  = 60,
  parameter bit KEEP_5V_OFF  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       slp_s3_n,
  input  logic       slp_s5_n,
  output logic [1:0] ps_code,
  output logic [1:0] rail_en
);
  logic [1:0] raw_req;
  logic [1:0] filt_req;
  logic       expire;
  logic       delay_run;
  pstate_e    state;

  assign raw_req = {slp_s5_n, slp_s3_n};

  for (genvar i = 0; i < 2; i++) begin : g_filt
    pin_deglitch #(.DEPTH(FILTER_TICKS)) u_dg (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .raw  (raw_req[i]),
      .filt (filt_req[i])
    );
  end

  s3_delay_timer #(.DELAY(DELAY_TICKS)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .run   (delay_run),
    .expire(expire)
  );

  power_state_fsm #(.KEEP_5V_OFF(KEEP_5V_OFF)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (filt_req),
    .expire   (expire),
    .state    (state),
    .delay_run(delay_run),
    .rails    (rail_en)
  );

  assign ps_code = state;

  // R2
  run_code_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_req == REQ_RUN |=> ps_code == 2'b00);

endmodule

// File: tb/sim_sleep_state_ctrl.sv
module sim_sleep_state_ctrl;
  localparam int FT = 4;
  localparam int DT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic s3_n = 1'b0;
  logic s5_n = 1'b0;
  logic [1:0] code0, code1, rail0, rail1;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sleep_state_ctrl #(.FILTER_TICKS(FT), .DELAY_TICKS(DT), .KEEP_5V_OFF(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slp_s3_n(s3_n), .slp_s5_n(s5_n),
    .ps_code(code0), .rail_en(rail0));
  sleep_state_ctrl #(.FILTER_TICKS(FT), .DELAY_TICKS(DT), .KEEP_5V_OFF(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slp_s3_n(s3_n), .slp_s5_n(s5_n),
    .ps_code(code1), .rail_en(rail1));

  // one-clock tick every fifth clock
  initial begin
    forever begin
      repeat (4) begin @(negedge clk); tick = 1'b0; end
      @(negedge clk); tick = 1'b1;
    end
  end

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] c);
    {s5_n, s3_n} = c;
  endtask

  function automatic logic [1:0] exp_state(logic [1:0] st, logic [1:0] c);
    case (c)
      2'b11:   return 2'b00;
      2'b10:   return (st == 2'b00) ? 2'b01 : st;
      2'b01:   return st;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] exp_rail(logic [1:0] st, logic keep);
    return {(st != 2'b10) | keep, 1'b1};
  endfunction

  task automatic go_state(input logic [1:0] st);
    if (st == 2'b10) begin
      drive(2'b00); wait_ticks(FT + 1);
    end else begin
      drive(2'b11); wait_ticks(FT + 1);
      if (st == 2'b01) begin drive(2'b10); wait_ticks(FT + DT + 1); end
    end
  endtask

  initial begin
    #4ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    drive(2'b00);
    repeat (6) @(negedge clk);
    // R1 during reset
    check("R1 reset state", code0, 2'b10);
    check("R9 reset rails u0", rail0, 2'b01);
    check("R9 reset rails u1", rail1, 2'b11);
    rst_n = 1'b1;
    wait_ticks(2);
    check("R1 after release", code0, 2'b10);

    // R2 wake from soft-off, exact cycle
    drive(2'b11);
    wait_ticks(FT);
    check("R2 not before clock after accept", code0, 2'b10);
    @(negedge clk);
    check("R2 active", code0, 2'b00);
    check("R9 active rails", rail0, 2'b11);

    // R8 short pulse of 00 ignored
    drive(2'b00); wait_ticks(FT - 1); drive(2'b11);
    wait_ticks(FT + 3);
    check("R8 short pulse ignored", code0, 2'b00);

    // R3 delay boundary
    drive(2'b10);
    wait_ticks(FT + DT - 1); @(negedge clk);
    check("R3 still active one tick early", code0, 2'b00);
    wait_ticks(1);
    check("R3 suspend on last tick", code0, 2'b01);
    check("R9 suspend rails", rail0, 2'b11);

    // R5 suspend to soft-off timing
    drive(2'b00);
    wait_ticks(FT - 1); @(negedge clk);
    check("R5 not yet off", code0, 2'b01);
    wait_ticks(1); @(negedge clk);
    check("R5 off", code0, 2'b10);
    check("R9 off rails u0", rail0, 2'b01);
    check("R9 off rails u1", rail1, 2'b11);

    // R4 cancel while delay runs, then full restart
    go_state(2'b00);
    drive(2'b10); wait_ticks(FT + 2);
    drive(2'b11); wait_ticks(FT + 1);
    check("R4 cancel keeps active", code0, 2'b00);
    drive(2'b10);
    wait_ticks(FT + DT - 1); @(negedge clk);
    check("R4 restart needs full delay", code0, 2'b00);
    wait_ticks(1);
    check("R4 restart reaches suspend", code0, 2'b01);

    // R6 / R7 sweep across start states and codes
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] st, e;
        st = 2'(s);
        go_state(st);
        check("R1 sweep start", code0, st);
        drive(2'(c));
        wait_ticks(FT + DT + 2);
        e = exp_state(st, 2'(c));
        check("R6 R7 sweep state u0", code0, e);
        check("R6 R7 sweep state u1", code1, e);
        check("R9 sweep rails u0", rail0, exp_rail(e, 1'b0));
        check("R9 sweep rails u1", rail1, exp_rail(e, 1'b1));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule